// File: doc/BRIEF.md
# Bus initiator back-to-back sequencer

This block is the control state machine of a simplified parallel-bus initiator. It takes requests from a queue, one at a time. Each request carries an address, a command code, a read/write flag and a count of data phases. For each request it drives the cycle-framing strobe, the initiator-ready strobe and the command/byte-enable lanes. It also drives the enable for the shared address/data lines. Every strobe is active-low and is modelled as a logic bit in which 0 means asserted.

When a transaction ends, the bus normally rests for one idle cycle so that another device can take over the shared lines. The sequencer can skip that cycle. It starts the next address phase straight after the final data phase when all of these hold:
- the finishing transaction was a write;
- the grant is still present;
- another request is waiting;
- the next target is known to be the same one. This is known when the upper address bits match, when an external same-target hint is given, or when a configuration bit declares that every target tolerates the early start.

A flag marks each transaction that starts this way.

Top module: `ini_b2b_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, frame_n and irdy_n read 1, cbe_n reads 4'hF, and ad_oe, b2b_start and req_pop read 0.
- R2: A transaction begins from rest only if req_valid is 1 and gnt_n is 0. Its address phase lasts exactly one cycle with frame_n=0, irdy_n=1, cbe_n equal to req_cmd and ad_oe=1, and req_pop is 1 in that same cycle.
- R3: A data phase drives irdy_n=0, cbe_n=4'h0 and ad_oe equal to the write flag. frame_n stays 0 in every data phase except the final one, where it is 1. A data phase completes only in a cycle where trdy_n and devsel_n are both 0; otherwise it repeats.
- R4: A request performs req_beats data phases, and a req_beats of 0 performs one.
- R5: When the final data phase completes and chaining is allowed, the next cycle is the address phase of the next request, with b2b_start=1 and no idle cycle between them.
- R6: After a read, the cycle that follows the final data phase is always idle: frame_n=1, irdy_n=1, cbe_n=4'hF, ad_oe=0.
- R7: If gnt_n is 1 in the cycle where the final data phase completes, the bus goes idle instead of chaining. A later start from rest then carries b2b_start=0.
- R8: Chaining after a write needs one of three conditions: the top HI_BITS address bits of the waiting request equal those of the previous address, same_tgt is 1, or cfg_b2b_all is 1. Otherwise an idle cycle is inserted.
- R9: After a single idle cycle, a waiting request with the grant present starts its address phase in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Queue head holds a request |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | 4 | Command code for the address phase |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | CNT_W | Number of data phases (0 treated as 1) |
| gnt_n | input | 1 | Bus grant, 0 = granted |
| trdy_n | input | 1 | Target ready, 0 = ready |
| devsel_n | input | 1 | Target claims the cycle, 0 = claimed |
| same_tgt | input | 1 | External hint that the next request hits the same target |
| cfg_b2b_all | input | 1 | All targets tolerate back-to-back starts |
| frame_n | output | 1 | Cycle framing strobe, 0 = asserted |
| irdy_n | output | 1 | Initiator ready, 0 = asserted |
| cbe_n | output | 4 | Command in the address phase, byte enables in data phases |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| b2b_start | output | 1 | High in an address phase entered without an idle cycle |
| req_pop | output | 1 | Removes the queue head, high in its address phase |

## Verification
The hardest case to reach is a grant that is withdrawn in exactly the cycle where the final data phase completes. For that case to be meaningful, the waiting request must otherwise qualify for chaining: it must be a write behind a write with matching upper address bits. The stimulus sets up such a pair with one data phase each. It then raises gnt_n in the cycle after the address phase, so the grant is gone at the moment of decision and not before. It holds the grant off for one more cycle to prove that the block stays at rest, and then restores it. The bench also inserts target wait states in both the middle and the final data phase. This shows that the chaining decision waits for the completing handshake and is not made merely on entry to the final phase.

// File: rtl/ini_pkg.sv
package ini_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_LAST = 3'd3,
    ST_TURN = 3'd4
  } ini_state_e;

  localparam logic [3:0] CBE_REST = 4'hF;
  localparam logic [3:0] CBE_ALL  = 4'h0;

endpackage

// File: rtl/ini_beatcnt.sv
module ini_beatcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_le1,
  output logic             rem_eq2
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)     rem_d = (load_val == '0) ? ONE : load_val;
    else if (dec) rem_d = rem_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= ONE;
    else        rem_q <= rem_d;
  end

  assign rem_le1 = (rem_q <= ONE);
  assign rem_eq2 = (rem_q == TWO);

endmodule

// File: rtl/ini_elig.sv
module ini_elig #(
  parameter int ADDR_W  = 32,
  parameter int HI_BITS = 8
) (
  input  logic              cur_write,
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              next_valid,
  input  logic              gnt_n,
  input  logic              same_tgt,
  input  logic              cfg_b2b_all,
  output logic              chain_ok
);

  localparam int LOW_BITS = ADDR_W - HI_BITS;

  logic [ADDR_W-1:0] diff;
  logic              addr_hit;
  logic              tgt_safe;

  assign diff     = prev_addr ^ next_addr;
  assign addr_hit = ((diff >> LOW_BITS) == '0);
  assign tgt_safe = addr_hit | same_tgt | cfg_b2b_all;
  assign chain_ok = cur_write & ~gnt_n & next_valid & tgt_safe;

endmodule

// File: rtl/ini_ctl.sv
module ini_ctl
  import ini_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  input  logic              req_write,
  input  logic              gnt_n,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic              chain_ok,
  input  logic              rem_le1,
  input  logic              rem_eq2,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              frame_n,
  output logic              irdy_n,
  output logic [3:0]        cbe_n,
  output logic              ad_oe,
  output logic              b2b_start,
  output logic              req_pop
);

  ini_state_e state_q, state_d;
  logic       accept, chain, xfer, start_ok, wr_sel;
  logic       frame_d, irdy_d, oe_d;
  logic [3:0] cbe_d;

  assign xfer     = ~trdy_n & ~devsel_n;
  assign start_ok = req_valid & ~gnt_n;

  // next-state logic
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    chain   = 1'b0;
    cnt_dec = 1'b0;
    case (state_q)
      ST_IDLE, ST_TURN: begin
        if (start_ok) begin
          state_d = ST_ADDR;
          accept  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_ADDR: state_d = rem_le1 ? ST_LAST : ST_DATA;
      ST_DATA: begin
        if (xfer) begin
          cnt_dec = 1'b1;
          if (rem_eq2) state_d = ST_LAST;
        end
      end
      ST_LAST: begin
        if (xfer) begin
          if (chain_ok) begin
            state_d = ST_ADDR;
            accept  = 1'b1;
            chain   = 1'b1;
          end else begin
            state_d = ST_TURN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_load = accept;
  assign wr_sel   = accept ? req_write : cur_write;

  // output decode from next state, registered below
  always_comb begin
    frame_d = 1'b1;
    irdy_d  = 1'b1;
    cbe_d   = CBE_REST;
    oe_d    = 1'b0;
    case (state_d)
      ST_ADDR: begin
        frame_d = 1'b0;
        cbe_d   = req_cmd;
        oe_d    = 1'b1;
      end
      ST_DATA: begin
        frame_d = 1'b0;
        irdy_d  = 1'b0;
        cbe_d   = CBE_ALL;
        oe_d    = wr_sel;
      end
      ST_LAST: begin
        irdy_d = 1'b0;
        cbe_d  = CBE_ALL;
        oe_d   = wr_sel;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      frame_n   <= 1'b1;
      irdy_n    <= 1'b1;
      cbe_n     <= CBE_REST;
      ad_oe     <= 1'b0;
      b2b_start <= 1'b0;
      req_pop   <= 1'b0;
    end else begin
      state_q   <= state_d;
      frame_n   <= frame_d;
      irdy_n    <= irdy_d;
      cbe_n     <= cbe_d;
      ad_oe     <= oe_d;
      b2b_start <= chain;
      req_pop   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_addr  <= '0;
    end else if (accept) begin
      cur_write <= req_write;
      cur_addr  <= req_addr;
    end
  end

  // the address phase is always followed by a data phase
  assert_addr_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && irdy_n) |=> !irdy_n);

  // the pop coincides with an address phase
  assert_pop_in_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |-> (!frame_n && irdy_n));

  // frame is only released with the initiator ready
  assert_frame_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> !irdy_n);

  // a completed read is followed by a released bus
  assert_read_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAST && !cur_write && xfer) |=> (frame_n && irdy_n && !ad_oe));

endmodule

// File: rtl/ini_b2b_seq.sv
module ini_b2b_seq #(
  parameter int ADDR_W  = 32,
  parameter int HI_BITS = 8,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  input  logic              req_write,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic              gnt_n,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic              same_tgt,
  input  logic              cfg_b2b_all,
  output logic              frame_n,
  output logic              irdy_n,
  output logic [3:0]        cbe_n,
  output logic              ad_oe,
  output logic              b2b_start,
  output logic              req_pop
);

  logic              chain_ok, rem_le1, rem_eq2, cnt_load, cnt_dec, cur_write;
  logic [ADDR_W-1:0] cur_addr;

  ini_beatcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (req_beats),
    .dec      (cnt_dec),
    .rem_le1  (rem_le1),
    .rem_eq2  (rem_eq2)
  );

  ini_elig #(.ADDR_W(ADDR_W), .HI_BITS(HI_BITS)) u_elig (
    .cur_write   (cur_write),
    .prev_addr   (cur_addr),
    .next_addr   (req_addr),
    .next_valid  (req_valid),
    .gnt_n       (gnt_n),
    .same_tgt    (same_tgt),
    .cfg_b2b_all (cfg_b2b_all),
    .chain_ok    (chain_ok)
  );

  ini_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_cmd   (req_cmd),
    .req_write (req_write),
    .gnt_n     (gnt_n),
    .trdy_n    (trdy_n),
    .devsel_n  (devsel_n),
    .chain_ok  (chain_ok),
    .rem_le1   (rem_le1),
    .rem_eq2   (rem_eq2),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .cur_write (cur_write),
    .cur_addr  (cur_addr),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .cbe_n     (cbe_n),
    .ad_oe     (ad_oe),
    .b2b_start (b2b_start),
    .req_pop   (req_pop)
  );

  // a chained start needs the grant at the decision edge
  assert_b2b_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b2b_start |-> $past(!gnt_n));

  // a chained start is an address phase
  assert_b2b_is_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b2b_start |-> (!frame_n && irdy_n && req_pop));

endmodule

// File: tb/ini_b2b_seq_bench.sv
`timescale 1ns/1ps
module ini_b2b_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gnt_n, trdy_n, devsel_n, same_tgt, cfg_b2b_all;
  logic        frame_n, irdy_n, ad_oe, b2b_start, req_pop;
  logic [3:0]  cbe_n;

  logic [31:0] q_addr  [9];
  logic        q_write [9];
  logic [3:0]  q_beats [9];
  int          q_n, q_idx;

  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_cmd, req_beats;

  int  n_chk, n_bad;
  bit  done;

  localparam logic [3:0] CMD_WR = 4'h7;
  localparam logic [3:0] CMD_RD = 4'h6;

  always #2.5 clk = ~clk;

  assign req_valid = (q_idx < q_n);
  assign req_addr  = q_addr[q_idx];
  assign req_write = q_write[q_idx];
  assign req_beats = q_beats[q_idx];
  assign req_cmd   = q_write[q_idx] ? CMD_WR : CMD_RD;

  ini_b2b_seq u_ini_b2b_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_write(req_write), .req_beats(req_beats),
    .gnt_n(gnt_n), .trdy_n(trdy_n), .devsel_n(devsel_n), .same_tgt(same_tgt),
    .cfg_b2b_all(cfg_b2b_all), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_oe(ad_oe), .b2b_start(b2b_start), .req_pop(req_pop)
  );

  // {gnt_n, trdy_n | frame_n, irdy_n, ad_oe, b2b_start, req_pop, cbe_n}
  localparam logic [10:0] VEC [15] = '{
    11'b0_0_0_1_1_0_1_0111, // 0 addr phase of write A
    11'b0_0_0_0_1_0_0_0000, // 1 data phase
    11'b0_1_0_0_1_0_0_0000, // 2 target wait, data repeats
    11'b0_0_1_0_1_0_0_0000, // 3 final data phase
    11'b0_0_0_1_1_1_1_0111, // 4 chained addr of write B
    11'b0_0_1_0_1_0_0_0000, // 5 one data phase only
    11'b0_1_1_0_1_0_0_0000, // 6 wait in final phase
    11'b0_0_1_1_0_0_0_1111, // 7 idle: other target
    11'b0_0_0_1_1_0_1_0110, // 8 addr phase of read
    11'b0_0_1_0_0_0_0_0000, // 9 read final phase, lines not driven
    11'b0_0_1_1_0_0_0_1111, // 10 idle after read
    11'b0_0_0_1_1_0_1_0111, // 11 restart right after idle
    11'b0_0_1_0_1_0_0_0000, // 12 final data phase
    11'b0_0_1_1_0_0_0_1111, // 13 queue empty, idle
    11'b0_0_1_1_0_0_0_1111  // 14 stays at rest
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:       return "R2";
      1, 2, 3: return "R3";
      4:       return "R5";
      5, 6:    return "R4";
      7:       return "R8";
      8, 9:    return "R3";
      10:      return "R6";
      11:      return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic push(input logic [31:0] a, input logic w, input logic [3:0] b);
    q_addr[q_n]  = a;
    q_write[q_n] = w;
    q_beats[q_n] = b;
    q_n++;
  endtask

  task automatic clear_q();
    q_n = 0;
    q_idx = 0;
  endtask

  task automatic cyc(input logic g, input logic t, input logic [10:0] exp, input string tag);
    logic [10:0] act;
    gnt_n  = g;
    trdy_n = t;
    @(posedge clk);
    @(negedge clk);
    act = {g, t, frame_n, irdy_n, ad_oe, b2b_start, req_pop, cbe_n};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", tag, act[8:0], exp[8:0]);
    end
    if (req_pop === 1'b1) q_idx++;
  endtask

  localparam logic [8:0] O_ADDR_W = 9'b0_1_1_0_1_0111;
  localparam logic [8:0] O_ADDR_B = 9'b0_1_1_1_1_0111;
  localparam logic [8:0] O_DATA_W = 9'b0_0_1_0_0_0000;
  localparam logic [8:0] O_LAST_W = 9'b1_0_1_0_0_0000;
  localparam logic [8:0] O_REST   = 9'b1_1_0_0_0_1111;

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    clear_q();
    gnt_n = 1'b1; trdy_n = 1'b1; devsel_n = 1'b0; same_tgt = 1'b0; cfg_b2b_all = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({frame_n, irdy_n, ad_oe, b2b_start, req_pop, cbe_n} !== O_REST) begin
      n_bad++;
      $display("FAIL R1: reset outputs %b expected %b",
               {frame_n, irdy_n, ad_oe, b2b_start, req_pop, cbe_n}, O_REST);
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, {2'b00, O_REST}, "R1");

    // table walk
    push(32'h1000_0000, 1'b1, 4'd2);
    push(32'h1000_0040, 1'b1, 4'd1);
    push(32'h2000_0000, 1'b0, 4'd1);
    push(32'h2000_0010, 1'b1, 4'd1);
    for (int i = 0; i < 15; i++) cyc(VEC[i][10], VEC[i][9], VEC[i], vec_tag(i));

    // R7: grant withdrawn in the final data phase of an eligible pair
    clear_q();
    push(32'h1000_0000, 1'b1, 4'd1);
    push(32'h1000_0080, 1'b1, 4'd1);
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R7");
    cyc(1'b1, 1'b0, {2'b10, O_LAST_W}, "R7");
    cyc(1'b1, 1'b0, {2'b10, O_REST},   "R7");
    cyc(1'b1, 1'b0, {2'b10, O_REST},   "R2");
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R7");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R7");
    cyc(1'b0, 1'b0, {2'b00, O_REST},   "R7");

    // R8: foreign target, chaining via configuration bit
    clear_q();
    cfg_b2b_all = 1'b1;
    push(32'h1000_0000, 1'b1, 4'd1);
    push(32'h3000_0000, 1'b1, 4'd1);
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_B}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_REST},   "R8");
    cfg_b2b_all = 1'b0;

    // R8: foreign target, chaining via same-target hint
    clear_q();
    same_tgt = 1'b1;
    push(32'h5000_0000, 1'b1, 4'd1);
    push(32'h7000_0000, 1'b1, 4'd1);
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_B}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R8");
    cyc(1'b0, 1'b0, {2'b00, O_REST},   "R8");
    same_tgt = 1'b0;

    // R4: zero beats performs a single data phase
    clear_q();
    push(32'h1000_0000, 1'b1, 4'd0);
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R4");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R4");
    cyc(1'b0, 1'b0, {2'b00, O_REST},   "R4");

    // R3: unclaimed cycle does not complete a data phase; three beats
    clear_q();
    push(32'h1000_0000, 1'b1, 4'd3);
    cyc(1'b0, 1'b0, {2'b00, O_ADDR_W}, "R3");
    cyc(1'b0, 1'b0, {2'b00, O_DATA_W}, "R3");
    devsel_n = 1'b1;
    cyc(1'b0, 1'b0, {2'b00, O_DATA_W}, "R3");
    devsel_n = 1'b0;
    cyc(1'b0, 1'b0, {2'b00, O_DATA_W}, "R4");
    cyc(1'b0, 1'b0, {2'b00, O_LAST_W}, "R4");
    cyc(1'b0, 1'b0, {2'b00, O_REST},   "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule